// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog timer on a small register bus. Software arms it by setting an enable bit in the mode register, together with a 4-bit code that picks the interval. It then has to keep restarting the countdown by writing one fixed key value to the control register. If the count is allowed to run out, the block either gives a single-cycle system reset pulse or raises a sticky interrupt, as the configuration register selects.

Time is measured in half-second ticks that come in on a tick input. An internal down-counter is loaded with the number of half-second ticks in the selected interval. It loads on a valid keyed restart, and also when the enable bit changes from 0 to 1. It only counts while the watchdog is enabled. When it runs out it reloads itself, so an interrupt-mode watchdog fires again after every interval that is not serviced. The bus reads back combinationally while the read strobe is high. Writes take effect at the clock edge.

Top module: `keyed_wdog`

## Requirements
- R1: A synchronous active-low reset clears every register and output: the watchdog is disabled, the code is 0, the action is 00, no interrupt is pending and no reset pulse is present.
- R2: Reads return zero while the read strobe is low, and zero from offset 0x10 (control). Offset 0x14 returns the 2-bit action in bits 1:0 with all other bits zero. Offset 0x18 returns the enable bit in bit 0 and the interval code in bits 7:4, with all other bits zero.
- R3: A write to 0x10 restarts the countdown only when bits 12:0 of the data equal 0x14AF (0xA57 shifted left by one, with bit 0 set). Bits above 12 are not compared. Any other value written there changes nothing.
- R4: The interval code selects a count of half-second ticks: 0 gives 1; 1 to 6 give twice the code; 7, 8, 9, 0xA and 0xB give 16, 20, 24, 28 and 32; 0xC to 0xF give 32.
- R5: A mode write that changes the enable bit from 0 to 1 loads the counter from the code in that same write. A mode write while the watchdog is already enabled does not restart the count.
- R6: The counter drops by one on each tick only while the watchdog is enabled. A write of 0 to the mode register stops it, and the remaining count is frozen.
- R7: A tick that arrives with one tick remaining is an expiry. The counter then reloads from the current code, so expiries repeat every interval.
- R8: With action 01, an expiry gives a sys_rst_pulse high for exactly the one cycle after the expiring tick.
- R9: With any action other than 01, an expiry sets irq_pend in the cycle after the expiring tick. irq_pend stays set until a write to 0x14 with bit 2 set. When an expiry and such a clear happen in the same cycle, the set wins.
- R10: A valid keyed restart in the same cycle as an expiring tick takes priority: no expiry action happens and the full interval is reloaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W (8) | Register byte offset |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | DATA_W (32) | Read data, valid while bus_re is high |
| tick_half | input | 1 | One-cycle pulse every half second |
| sys_rst_pulse | output | 1 | One-cycle system reset request |
| irq_pend | output | 1 | Sticky expiry interrupt |

## Verification
The embedded assertions check, on every cycle, properties that hold whatever the stimulus. The counter never changes while the watchdog is disabled and not being loaded. It is never zero while enabled. It drops by exactly one on an ordinary tick. Each reset pulse and each new interrupt follows a tick. A pending interrupt only goes away through a clear write. Other behaviours depend on the sequence of events, and only the bench scenarios can show them: the exact length of the interval for each of the sixteen codes, the rejection of a near-miss key, the winner when a restart and an expiry land together, the winner when a set and a clear collide, and the fact that re-enabling an already running watchdog has no effect. The bench compares these against a behavioural model on every clock.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  // register offsets (byte addresses)
  localparam int OFS_CTRL = 'h10;
  localparam int OFS_CFG  = 'h14;
  localparam int OFS_MODE = 'h18;

  // restart key: bits 12:1 hold 0xA57, bit 0 set
  localparam int          KEY_W   = 13;
  localparam logic [12:0] KEY_VAL = {12'hA57, 1'b1};

  // field positions
  localparam int EN_BIT   = 0;
  localparam int CODE_LSB = 4;
  localparam int CODE_W   = 4;
  localparam int ACT_W    = 2;
  localparam int CLR_BIT  = 2;

  // longest interval in half-second ticks
  localparam int HALVES_MAX = 32;
  localparam int CNT_W      = $clog2(HALVES_MAX + 1);

  typedef enum logic [ACT_W-1:0] {
    ACT_IRQ   = 2'b00,
    ACT_RESET = 2'b01,
    ACT_SPARE2 = 2'b10,
    ACT_SPARE3 = 2'b11
  } act_t;

  // interval code -> number of half-second ticks
  function automatic logic [CNT_W-1:0] halves_for_code(input logic [CODE_W-1:0] c);
    logic [CNT_W-1:0] r;
    if (c == '0)
      r = CNT_W'(1);
    else if (c <= 4'd6)
      r = CNT_W'({2'b00, c} << 1);
    else if (c <= 4'd11)
      r = CNT_W'(({2'b00, c} - 6'd3) << 2);
    else
      r = CNT_W'(HALVES_MAX);
    return r;
  endfunction
endpackage

// File: rtl/kwd_regfile.sv
module kwd_regfile
  import kwd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wd_en,
  output logic [CODE_W-1:0] wd_code,
  output act_t              wd_act,
  output logic              reload_cmd,
  output logic              arm_evt,
  output logic              irq_clr,
  output logic [CODE_W-1:0] arm_code
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFS_CFG);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(OFS_MODE);

  logic wr_ctrl, wr_cfg, wr_mode;
  logic [DATA_W-1:0] rd_mux;
  logic unused_wdata;

  assign wr_ctrl = bus_we && (bus_addr == A_CTRL);
  assign wr_cfg  = bus_we && (bus_addr == A_CFG);
  assign wr_mode = bus_we && (bus_addr == A_MODE);

  // named internal events
  assign reload_cmd = wr_ctrl && (bus_wdata[KEY_W-1:0] == KEY_VAL);
  assign arm_evt    = wr_mode && bus_wdata[EN_BIT] && !wd_en;
  assign irq_clr    = wr_cfg && bus_wdata[CLR_BIT];
  assign arm_code   = bus_wdata[CODE_LSB +: CODE_W];
  assign unused_wdata = ^bus_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wd_en   <= 1'b0;
      wd_code <= '0;
      wd_act  <= ACT_IRQ;
    end else begin
      if (wr_mode) begin
        wd_en   <= bus_wdata[EN_BIT];
        wd_code <= bus_wdata[CODE_LSB +: CODE_W];
      end
      if (wr_cfg)
        wd_act <= act_t'(bus_wdata[ACT_W-1:0]);
    end
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr == A_CFG)
      rd_mux[ACT_W-1:0] = wd_act;
    else if (bus_addr == A_MODE) begin
      rd_mux[EN_BIT] = wd_en;
      rd_mux[CODE_LSB +: CODE_W] = wd_code;
    end
  end

  assign bus_rdata = bus_re ? rd_mux : '0;

  // R5: an arming write always leaves the watchdog enabled
  assert_arm_enables_R5: assert property (@(posedge clk) disable iff (!rst_n)
    arm_evt |=> wd_en);
  // R3: a control write never alters the stored mode or action
  assert_ctrl_no_side_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !reload_cmd) |=> ($stable(wd_en) && $stable(wd_code) && $stable(wd_act)));
endmodule

// File: rtl/kwd_countdown.sv
module kwd_countdown
  import kwd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tick,
  input  logic              reload_cmd,
  input  logic              arm_evt,
  input  logic [CODE_W-1:0] arm_code,
  input  logic [CODE_W-1:0] cur_code,
  output logic              expire_evt
);
  logic [CNT_W-1:0] remaining;
  logic             load_req;
  logic             step_evt;

  assign load_req   = reload_cmd || arm_evt;
  assign expire_evt = en && tick && (remaining == CNT_W'(1)) && !load_req;
  assign step_evt   = en && tick && !load_req && !expire_evt;

  always_ff @(posedge clk) begin
    if (!rst_n)
      remaining <= '0;
    else if (arm_evt)
      remaining <= halves_for_code(arm_code);
    else if (reload_cmd || expire_evt)
      remaining <= halves_for_code(cur_code);
    else if (step_evt)
      remaining <= remaining - CNT_W'(1);
  end

  // R6: nothing moves the counter while disabled and not loaded
  assert_hold_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !load_req) |=> $stable(remaining));
  // R6: a plain tick takes exactly one off
  assert_single_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && !load_req && remaining > CNT_W'(1)) |=> (remaining == $past(remaining) - CNT_W'(1)));
  // R7: an enabled counter is never empty
  assert_nonzero_enabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (remaining != '0));
endmodule

// File: rtl/kwd_action.sv
module kwd_action
  import kwd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic expire_evt,
  input  act_t act,
  input  logic irq_clr,
  input  logic tick,
  output logic sys_rst_pulse,
  output logic irq_pend
);
  logic want_reset;
  logic want_irq;

  assign want_reset = expire_evt && (act == ACT_RESET);
  assign want_irq   = expire_evt && (act != ACT_RESET);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sys_rst_pulse <= 1'b0;
      irq_pend      <= 1'b0;
    end else begin
      sys_rst_pulse <= want_reset;
      if (want_irq)
        irq_pend <= 1'b1;
      else if (irq_clr)
        irq_pend <= 1'b0;
    end
  end

  // R8: a reset pulse always follows a tick
  assert_pulse_after_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_pulse |-> $past(tick));
  // R9: a fresh interrupt always follows a tick
  assert_irq_after_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pend) |-> $past(tick));
  // R9: pending stays until cleared
  assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend && !irq_clr) |=> irq_pend);
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import kwd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tick_half,
  output logic              sys_rst_pulse,
  output logic              irq_pend
);
  logic              wd_en;
  logic [CODE_W-1:0] wd_code;
  act_t              wd_act;
  logic              reload_cmd;
  logic              arm_evt;
  logic              irq_clr;
  logic [CODE_W-1:0] arm_code;
  logic              expire_evt;

  kwd_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
    .bus_rdata(bus_rdata),
    .wd_en(wd_en), .wd_code(wd_code), .wd_act(wd_act),
    .reload_cmd(reload_cmd), .arm_evt(arm_evt), .irq_clr(irq_clr), .arm_code(arm_code)
  );

  kwd_countdown u_count (
    .clk(clk), .rst_n(rst_n), .en(wd_en), .tick(tick_half),
    .reload_cmd(reload_cmd), .arm_evt(arm_evt),
    .arm_code(arm_code), .cur_code(wd_code),
    .expire_evt(expire_evt)
  );

  kwd_action u_act (
    .clk(clk), .rst_n(rst_n), .expire_evt(expire_evt), .act(wd_act),
    .irq_clr(irq_clr), .tick(tick_half),
    .sys_rst_pulse(sys_rst_pulse), .irq_pend(irq_pend)
  );

  // R8/R9: one expiry never produces both outcomes
  assert_one_outcome_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_pulse |-> !$rose(irq_pend));
endmodule

// File: tb/keyed_wdog_test.sv
`timescale 1ns/1ps
module keyed_wdog_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic        tick_half = 1'b0;
  logic        sys_rst_pulse;
  logic        irq_pend;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  bit finished = 0;

  always #2.5 clk = ~clk;

  keyed_wdog uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .tick_half(tick_half), .sys_rst_pulse(sys_rst_pulse), .irq_pend(irq_pend)
  );

  // ---------------- behavioural reference ----------------
  int m_en, m_code, m_act, m_left, m_rst, m_irq;

  function automatic int secs_halves(input int c);
    int s;
    if (c == 0) return 1;
    if (c <= 6) s = c;
    else if (c <= 11) s = 2 * c - 6;
    else s = 16;
    return 2 * s;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_code = 0; m_act = 0; m_left = 0; m_rst = 0; m_irq = 0;
    end else begin
      bit key_ok, arm, fire;
      key_ok = bus_we && bus_addr == 8'h10 && bus_wdata[12:0] == 13'h14AF;
      arm    = bus_we && bus_addr == 8'h18 && bus_wdata[0] && m_en == 0;
      fire   = m_en != 0 && tick_half && m_left == 1 && !key_ok && !arm;
      if (arm) m_left = secs_halves(int'(bus_wdata[7:4]));
      else if (key_ok || fire) m_left = secs_halves(m_code);
      else if (m_en != 0 && tick_half) m_left = m_left - 1;
      m_rst = (fire && m_act == 1) ? 1 : 0;
      if (fire && m_act != 1) m_irq = 1;
      else if (bus_we && bus_addr == 8'h14 && bus_wdata[2]) m_irq = 0;
      if (bus_we && bus_addr == 8'h14) m_act = int'(bus_wdata[1:0]);
      if (bus_we && bus_addr == 8'h18) begin
        m_en = int'(bus_wdata[0]); m_code = int'(bus_wdata[7:4]);
      end
    end
  end

  function automatic logic [31:0] model_read(input logic [7:0] a, input logic re);
    if (!re) return 32'h0;
    if (a == 8'h14) return 32'(m_act);
    if (a == 8'h18) return 32'((m_code << 4) | m_en);
    return 32'h0;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  logic last_rst;
  logic last_irq;

  // one clock: compare registered outputs, then drive, then compare read data
  task automatic step(input logic we, input logic re, input logic [7:0] a,
                      input logic [31:0] d, input logic tk);
    @(negedge clk);
    last_rst = sys_rst_pulse;
    last_irq = irq_pend;
    check(cur_req, "sys_rst_pulse", int'(sys_rst_pulse), m_rst);
    check(cur_req, "irq_pend", int'(irq_pend), m_irq);
    bus_we = we; bus_re = re; bus_addr = a; bus_wdata = d; tick_half = tk;
    #1;
    if (re) check(cur_req, "bus_rdata", int'(bus_rdata), int'(model_read(a, re)));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 8'h0, 32'h0, 0);
  endtask
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    step(1, 0, a, d, 0);
  endtask
  task automatic rd(input logic [7:0] a);
    step(0, 1, a, 32'h0, 0);
  endtask
  task automatic tick1();
    step(0, 0, 8'h0, 32'h0, 1);
    step(0, 0, 8'h0, 32'h0, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seen;
    // R1: reset state
    cur_req = "R1";
    idle(3);
    rst_n = 1'b1;
    step(0, 1, 8'h18, 0, 0);
    step(0, 1, 8'h14, 0, 0);
    check("R1", "irq after reset", int'(irq_pend), 0);
    check("R1", "pulse after reset", int'(sys_rst_pulse), 0);

    // R2: readback and masking
    cur_req = "R2";
    wr(8'h18, 32'h0000_0050);
    rd(8'h18);
    check("R2", "mode readback", int'(bus_rdata), 32'h50);
    wr(8'h18, 32'hFFFF_FF5E);
    rd(8'h18);
    check("R2", "mode masked", int'(bus_rdata), 32'h50);
    wr(8'h14, 32'hFFFF_FFF9);
    rd(8'h14);
    check("R2", "cfg masked", int'(bus_rdata), 32'h1);
    rd(8'h10);
    check("R2", "ctrl reads zero", int'(bus_rdata), 0);
    step(0, 0, 8'h14, 0, 0);
    check("R2", "no strobe zero", int'(bus_rdata), 0);

    // R4: every code, armed from disabled, measured in ticks (action 01)
    cur_req = "R4";
    for (int c = 0; c < 16; c++) begin
      int n;
      wr(8'h18, 32'h0);
      wr(8'h18, 32'((c << 4) | 1));
      n = 0;
      seen = 0;
      while (seen == 0 && n < 40) begin
        tick1();
        n++;
        if (last_rst) seen = 1;
      end
      check("R4", $sformatf("ticks for code %0d", c), n, secs_halves(c));
    end

    // R7/R8: periodic expiry, code 1 (2 ticks), count pulses over 8 ticks
    cur_req = "R8";
    wr(8'h18, 32'h0);
    wr(8'h18, 32'h11);
    seen = 0;
    for (int i = 0; i < 8; i++) begin
      tick1();
      if (last_rst) seen++;
    end
    check("R7", "repeat expiries", seen, 4);

    // R3: wrong key ignored, key with high bits set accepted (code 2 = 4 ticks)
    cur_req = "R3";
    wr(8'h18, 32'h0);
    wr(8'h18, 32'h21);
    tick1(); tick1(); tick1();
    wr(8'h10, 32'h0000_14AE);
    tick1();
    check("R3", "bad key no restart", int'(last_rst), 1);
    tick1(); tick1(); tick1();
    wr(8'h10, 32'hFFFF_14AF);
    tick1();
    check("R3", "key restarts", int'(last_rst), 0);
    tick1(); tick1();
    tick1();
    check("R3", "expiry after restart", int'(last_rst), 1);

    // R10: restart collides with expiring tick
    cur_req = "R10";
    tick1(); tick1(); tick1();
    step(1, 0, 8'h10, 32'h0000_14AF, 1);
    step(0, 0, 8'h0, 0, 0);
    check("R10", "restart beats expiry", int'(last_rst), 0);

    // R5: re-writing enable while running does not restart
    cur_req = "R5";
    tick1(); tick1(); tick1();
    wr(8'h18, 32'h21);
    tick1();
    check("R5", "no re-arm while enabled", int'(last_rst), 1);

    // R6: stop freezes the count
    cur_req = "R6";
    tick1(); tick1(); tick1();
    wr(8'h18, 32'h0);
    seen = 0;
    for (int i = 0; i < 10; i++) begin
      tick1();
      if (last_rst) seen++;
    end
    check("R6", "no expiry while stopped", seen, 0);
    step(1, 0, 8'h18, 32'h20, 0);
    step(1, 0, 8'h10, 32'h14AF, 0);
    step(0, 0, 8'h0, 0, 0);
    check("R6", "still idle", int'(last_rst), 0);

    // R9: interrupt mode, stickiness, clear, set-beats-clear
    cur_req = "R9";
    wr(8'h14, 32'h2);
    wr(8'h18, 32'h01);
    tick1();
    step(0, 0, 8'h0, 0, 0);
    check("R9", "irq set", int'(last_irq), 1);
    idle(5);
    check("R9", "irq sticky", int'(last_irq), 1);
    wr(8'h14, 32'h4);
    step(0, 0, 8'h0, 0, 0);
    check("R9", "irq cleared", int'(last_irq), 0);
    tick1();
    step(1, 0, 8'h14, 32'h4, 1);
    step(0, 0, 8'h0, 0, 0);
    check("R9", "set beats clear", int'(last_irq), 1);
    check("R8", "no pulse in irq mode", int'(last_rst), 0);

    // R1: reset mid-run clears everything
    cur_req = "R1";
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    step(0, 1, 8'h18, 0, 0);
    check("R1", "mode after reset", int'(bus_rdata), 0);
    check("R1", "irq after reset", int'(irq_pend), 0);
    idle(2);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule